// File: doc/BRIEF.md
# Burst Address Control Unit

This block turns a single registered start address into the four word addresses of a burst for a synchronous memory. A burst begins when either of two address strobes is sampled high on a rising clock edge: one strobe belongs to a processor, the other to a cache controller. The full 16-bit address is captured at that edge. From then on, the upper bits stay fixed. The two low bits are generated internally and step only on cycles where the advance input is high.

The ordering within the four-word block is chosen by a mode pin and sampled together with the strobe. It is either linear, counting up and wrapping within the block, or interleaved, where the start value is XORed with a 0..3 count. Three chip-enable inputs are decoded at the starting strobe into a registered select flag for the datapath, so that several devices can share a data bus in depth.

The processor strobe is ignored while the first enable is high. The cache-controller strobe is not blocked that way.

Top module: `burst_addr_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released until a strobe starts a burst, `addr_out` is 0 and `sel_q` is 0.
- R2: On a clock edge where a burst starts, `addr_out` takes the value of `addr_in` from that edge. It is visible right after the edge.
- R3: `ads_cpu` has no effect while `ce1_n` is 1: address, order and select flag all keep their values.
- R4: `ads_cache` starts a burst whatever the value of `ce1_n`.
- R5: With `order_lin` = 1 sampled at the start, the low two bits after k counted advances equal (start + k) mod 4.
- R6: With `order_lin` = 0 sampled at the start, the low two bits after k counted advances equal start XOR (k mod 4).
- R7: On an edge with no effective strobe and `adv` low, `addr_out` stays unchanged.
- R8: An effective strobe wins over `adv` on the same edge. It reloads the address and restarts the count at zero.
- R9: `sel_q` becomes 1 only when, at the starting strobe, `ce1_n` = 0, `ce2` = 1 and `ce3_n` = 0. Otherwise it becomes 0, and it holds its value between strobes.
- R10: Bits 15 to 2 of `addr_out` do not change during a burst, including when the low bits wrap.
- R11: A change of `order_lin` in the middle of a burst does not alter the ordering of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 16 | Start address, sampled with a strobe |
| ads_cpu | input | 1 | Processor address strobe, active high, blocked while ce1_n is high |
| ads_cache | input | 1 | Cache-controller address strobe, active high |
| adv | input | 1 | Advance to the next burst word, active high |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order, sampled with a strobe |
| ce1_n | input | 1 | First chip enable, active low |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| addr_out | output | 16 | Current burst word address |
| sel_q | output | 1 | Registered device-selected flag |

## Verification
The bench sweeps every start value of the low bits in both orders and from both strobes, and follows each burst through its wrap back to the start. A unit that carried into bit 2, or that applied the wrong order, would show a wrong upper or low field there. All eight chip-enable combinations are applied with the cache strobe. That catches a select decode with a wrong polarity, and a cache strobe that was wrongly gated by the first enable. A blocked processor strobe, a strobe arriving together with advance, and a mid-burst flip of the mode pin are each driven on their own. These expose a design that lets the processor strobe through, or lets advance win over the strobe, or reads the mode pin live.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int unsigned BA_ADDR_W  = 16;
  localparam int unsigned BA_BURST_W = 2;

  typedef enum logic {
    ORD_INTERLEAVED = 1'b0,
    ORD_LINEAR      = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bac_cs_decode.sv
module bac_cs_decode (
  input  logic ads_cpu,
  input  logic ads_cache,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  output logic start,
  output logic sel_next
);
  logic cpu_ok;

  // processor strobe gated by first enable; cache strobe is not
  assign cpu_ok   = ads_cpu & ~ce1_n;
  assign start    = cpu_ok | ads_cache;
  assign sel_next = ~ce1_n & ce2 & ~ce3_n;
endmodule

// File: rtl/bac_seq_counter.sv
module bac_seq_counter #(
  parameter int unsigned BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               adv,
  output logic [BURST_W-1:0] seq
);
  always_ff @(posedge clk) begin
    if (rst)       seq <= '0;
    else if (load) seq <= '0;
    else if (adv)  seq <= seq + 1'b1;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(seq));
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (seq == '0));
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && adv) |=> (seq == $past(seq) + 1'b1));
endmodule

// File: rtl/bac_order.sv
module bac_order
  import burst_addr_pkg::*;
#(
  parameter int unsigned BURST_W = 2
) (
  input  logic [BURST_W-1:0] base_lo,
  input  logic [BURST_W-1:0] seq,
  input  burst_order_e       mode,
  output logic [BURST_W-1:0] lo
);
  logic [BURST_W-1:0] lin_lo;
  logic [BURST_W-1:0] ilv_lo;

  assign lin_lo = base_lo + seq;

  for (genvar b = 0; b < BURST_W; b++) begin : g_ilv
    assign ilv_lo[b] = base_lo[b] ^ seq[b];
  end

  assign lo = (mode == ORD_LINEAR) ? lin_lo : ilv_lo;
endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W  = BA_ADDR_W,
  parameter int unsigned BURST_W = BA_BURST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ads_cpu,
  input  logic              ads_cache,
  input  logic              adv,
  input  logic              order_lin,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic              sel_q
);
  localparam int unsigned HI_W = ADDR_W - BURST_W;

  logic               start;
  logic               sel_next;
  logic [ADDR_W-1:0]  base_q;
  burst_order_e       mode_q;
  logic [BURST_W-1:0] seq;
  logic [BURST_W-1:0] lo;

  bac_cs_decode u_cs (
    .ads_cpu  (ads_cpu),
    .ads_cache(ads_cache),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .start    (start),
    .sel_next (sel_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mode_q <= ORD_INTERLEAVED;
      sel_q  <= 1'b0;
    end else if (start) begin
      base_q <= addr_in;
      mode_q <= burst_order_e'(order_lin);
      sel_q  <= sel_next;
    end
  end

  bac_seq_counter #(.BURST_W(BURST_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .load(start),
    .adv (adv),
    .seq (seq)
  );

  bac_order #(.BURST_W(BURST_W)) u_ord (
    .base_lo(base_q[BURST_W-1:0]),
    .seq    (seq),
    .mode   (mode_q),
    .lo     (lo)
  );

  assign addr_out = {base_q[ADDR_W-1:BURST_W], lo};

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (addr_out == $past(addr_in)));
  p_cpu_block_r3: assert property (@(posedge clk) disable iff (rst)
    (ads_cpu && ce1_n && !ads_cache && !adv) |=> ($stable(addr_out) && $stable(sel_q)));
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(sel_q));
  p_upper_r10: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(addr_out[ADDR_W-1:BURST_W]));
  p_ilv_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == ORD_INTERLEAVED) |-> ((addr_out[BURST_W-1:0] ^ base_q[BURST_W-1:0]) == seq));
  p_mode_r11: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(mode_q));
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (addr_out == '0 && sel_q == 1'b0));

  if (HI_W == 0) begin : g_bad_width
    initial $error("burst width must be narrower than address");
  end
endmodule

// File: tb/burst_addr_ctrl_test.sv
`timescale 1ns/1ps
module burst_addr_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr_in;
  logic        ads_cpu, ads_cache, adv, order_lin;
  logic        ce1_n, ce2, ce3_n;
  logic [15:0] addr_out;
  logic        sel_q;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  burst_addr_ctrl uut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .ads_cpu(ads_cpu),
    .ads_cache(ads_cache), .adv(adv), .order_lin(order_lin),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .addr_out(addr_out), .sel_q(sel_q)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    ads_cpu = 0; ads_cache = 0; adv = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [1:0] exp_lo(input bit lin, input logic [1:0] s, input int k);
    logic [1:0] kk = 2'(k);
    return lin ? 2'(s + kk) : (s ^ kk);
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [15:0] held;
    rst = 1; addr_in = 16'hFFFF; order_lin = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    ads_cpu = 1; ads_cache = 1; adv = 1;
    #1; tick(); tick();
    chk("R1 addr in reset", addr_out, 16'h0);
    chk("R1 sel in reset", {15'b0, sel_q}, 16'h0);
    idle(); rst = 0; tick();
    chk("R1 addr after reset", addr_out, 16'h0);
    chk("R1 sel after reset", {15'b0, sel_q}, 16'h0);

    // R5 R6 R2 R10: sweep strobe, order and start value
    for (int st = 0; st < 2; st++) begin
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 4; s++) begin
          a = 16'((16'h9A5C + st * 16'h1230 + m * 16'h0410 + s * 16'h0104) & 16'hFFFC) | 16'(s);
          idle(); addr_in = a; order_lin = m[0]; ce1_n = 0; ce2 = 1; ce3_n = 0;
          if (st == 0) ads_cpu = 1; else ads_cache = 1;
          tick();
          chk("R2 load", addr_out, a);
          idle();
          for (int k = 1; k <= 5; k++) begin
            adv = 1; tick(); adv = 0;
            chk(m ? "R5 linear step" : "R6 interleave step",
                addr_out, {a[15:2], exp_lo(m[0], a[1:0], k)});
            chk("R10 upper fixed", {2'b0, addr_out[15:2]}, {2'b0, a[15:2]});
          end
          held = addr_out;
          tick(); tick();
          chk("R7 hold", addr_out, held);
        end
      end
    end

    // R9 R4: all enable combinations with cache strobe
    for (int e = 0; e < 8; e++) begin
      a = 16'h4000 + 16'(e * 16'h0111);
      idle(); addr_in = a; order_lin = 1;
      ce1_n = e[2]; ce2 = e[1]; ce3_n = e[0]; ads_cache = 1;
      tick(); idle();
      chk("R4 cache strobe loads", addr_out, a);
      chk("R9 select decode", {15'b0, sel_q}, {15'b0, (e == 2)});
      ce1_n = ~e[2]; ce2 = ~e[1]; ce3_n = ~e[0];
      adv = 1; tick(); idle();
      chk("R9 select holds", {15'b0, sel_q}, {15'b0, (e == 2)});
    end

    // R3: processor strobe blocked while ce1_n high
    idle(); addr_in = 16'h1235; order_lin = 1; ce1_n = 0; ce2 = 1; ce3_n = 0; ads_cpu = 1;
    tick(); idle();
    chk("R9 select by cpu", {15'b0, sel_q}, 16'h1);
    addr_in = 16'hBEEF; order_lin = 0; ce1_n = 1; ads_cpu = 1;
    tick(); idle();
    chk("R3 cpu blocked addr", addr_out, 16'h1235);
    chk("R3 cpu blocked sel", {15'b0, sel_q}, 16'h1);
    adv = 1; tick(); idle();
    chk("R3 order kept linear", addr_out, 16'h1236);

    // R8: strobe with advance on same edge
    addr_in = 16'h7772; order_lin = 1; ce1_n = 0; ads_cpu = 1; adv = 1;
    tick(); idle();
    chk("R8 strobe beats adv", addr_out, 16'h7772);
    adv = 1; tick(); idle();
    chk("R8 count restarted", addr_out, 16'h7773);
    adv = 1; ads_cache = 1; addr_in = 16'h0101;
    tick(); idle();
    chk("R8 cache strobe beats adv", addr_out, 16'h0101);

    // R11: mode flipped mid-burst
    addr_in = 16'hC3C1; order_lin = 0; ads_cache = 1;
    tick(); idle();
    order_lin = 1; adv = 1; tick();
    chk("R11 interleave kept k1", addr_out, 16'hC3C0);
    tick(); idle();
    chk("R11 interleave kept k2", addr_out, 16'hC3C3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule